// File: doc/BRIEF.md
# Extension Parity Generator for Quasi-Cyclic LDPC Codewords

This block builds the low-rate tail of a quasi-cyclic LDPC codeword. It is given the information blocks and the four core parity blocks, which an upstream solver has already computed. From these it produces the extension parity blocks, each Z bits wide. The extension section of the parity-check matrix is an identity, so each extension block is the XOR of rotated copies of information and core parity blocks. No extension block depends on any other, and one row is finished every clock.

The rotation amount of each row, and whether each column contributes at all, come from a writable coefficient store. It holds one entry per extension row and per column. A start pulse captures the inputs and the number of extension rows wanted. The block then streams the whole codeword, one block per cycle, under a valid/ready handshake. The stream carries the information blocks first, then the core parity blocks, then the extension blocks. A last flag marks the final beat.

Top module: `ldpc_ext_parity`

## Requirements
- R1: After reset, valid_o and last_o are low and every coefficient entry is disabled, so every extension block is all zeros.
- R2: A write with coef_we_i high stores coef_val_i at (coef_row_i, coef_col_i). Columns 0..KB-1 address information blocks 1..KB, and columns KB..KB+G-1 address core parity blocks 1..G. A write to a row at or above ROWS, or to a column at or above KB+G, changes no entry.
- R3: Extension block r (0-based row r) equals the XOR, over all enabled columns c, of block c rotated by that entry's shift. A block b rotated by k has bit i equal to b[(i+k) mod Z], where bit i is bus bit i of the block.
- R4: A coefficient entry is coef_val_i[SW:0]. Bit SW is the enable and bits SW-1:0 are the shift. An entry whose enable is 0 contributes an all-zero block.
- R5: A stored shift value of Z or more is taken modulo Z.
- R6: The stream order is information blocks 1..KB, then core parity blocks 1..G, then extension blocks 1..N. Information block j is info_i[(j-1)*Z +: Z] and core block j is core_i[(j-1)*Z +: Z]. last_o is high only on extension block N.
- R7: N is nrows_i clamped into 1..ROWS: a value of 0 gives 1, and a value above ROWS gives ROWS.
- R8: The first block is valid in the second cycle after the start cycle. With ready_i held high, the KB+G+N blocks follow on consecutive cycles with no gap.
- R9: While valid_o is high and ready_i is low, blk_o, valid_o and last_o hold their values.
- R10: info_i, core_i and nrows_i are captured in the start cycle, and later changes to them are ignored. start_i is ignored while a codeword is in flight, including the cycle in which the last block is accepted.
- R11: In the cycle after the last block is accepted, valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_row_i | input | 6 | Extension row of the write |
| coef_col_i | input | 5 | Column of the write |
| coef_val_i | input | 5 | {enable, shift} |
| start_i | input | 1 | Start a codeword |
| nrows_i | input | 6 | Requested extension row count |
| info_i | input | 264 | Information blocks, block 1 in the low bits |
| core_i | input | 48 | Core parity blocks, block 1 in the low bits |
| blk_o | output | 12 | Output block |
| valid_o | output | 1 | Output block valid |
| last_o | output | 1 | Final block of the codeword |
| ready_i | input | 1 | Downstream accepts the block |

## Verification
The interaction of concern is a start request arriving in the same cycle as the acceptance of the final block. That is the one cycle where the idle condition is about to become true. The bench watches for last_o with ready_i high and raises start_i in exactly that cycle. It then requires valid_o to stay low for several cycles, which shows that the request was dropped and not taken as a new codeword. A second case stalls the stream with random ready_i. Mid-stream, it pulses start_i with a different row count and checks that the stream length and contents stay those of the first request.

// File: rtl/ldpc_ext_pkg.sv
package ldpc_ext_pkg;
  typedef enum logic [1:0] {
    SEG_INFO = 2'd0,
    SEG_CORE = 2'd1,
    SEG_EXT  = 2'd2
  } seg_e;
endpackage

// File: rtl/ext_coef_store.sv
module ext_coef_store #(
  parameter int ROWS  = 42,
  parameter int COLS  = 26,
  parameter int CW    = 5,
  parameter int ROW_W = 6,
  parameter int COL_W = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ROW_W-1:0]     wrow_i,
  input  logic [COL_W-1:0]     wcol_i,
  input  logic [CW-1:0]        wval_i,
  input  logic [ROW_W-1:0]     rrow_i,
  output logic [COLS*CW-1:0]   rrow_o
);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

  logic [CW-1:0] mem_q [ROWS][COLS];
  logic          wr_ok;
  logic [ROW_W-1:0] rsel;

  assign wr_ok = we_i && (wrow_i <= ROW_LAST) && (wcol_i <= COL_LAST);
  assign rsel  = (rrow_i <= ROW_LAST) ? rrow_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          mem_q[r][c] <= '0;
    end else if (wr_ok) begin
      mem_q[wrow_i][wcol_i] <= wval_i;
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_rd
    assign rrow_o[c*CW +: CW] = mem_q[rsel][c];
  end
endmodule

// File: rtl/ext_blk_rot.sv
module ext_blk_rot #(
  parameter int Z  = 12,
  parameter int SW = 4
) (
  input  logic [Z-1:0]  blk_i,
  input  logic [SW-1:0] sh_i,
  output logic [Z-1:0]  blk_o
);
  localparam logic [SW:0] Z_W = (SW+1)'(Z);

  logic [SW:0]    sh_w;
  logic [SW:0]    sh_m;
  logic [2*Z-1:0] dbl;

  assign sh_w = {1'b0, sh_i};
  // codes at or above Z wrap once; SW is sized so one subtract suffices
  assign sh_m = (sh_w >= Z_W) ? (sh_w - Z_W) : sh_w;
  assign dbl  = {blk_i, blk_i} >> sh_m;
  assign blk_o = dbl[Z-1:0];
endmodule

// File: rtl/ext_row_xor.sv
module ext_row_xor #(
  parameter int Z    = 12,
  parameter int SW   = 4,
  parameter int COLS = 26,
  parameter int CW   = SW + 1
) (
  input  logic [COLS*Z-1:0]  blk_i,
  input  logic [COLS*CW-1:0] coef_i,
  output logic [Z-1:0]       par_o
);
  logic [Z-1:0] term [COLS];

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [Z-1:0] rot;
    ext_blk_rot #(.Z(Z), .SW(SW)) u_rot (
      .blk_i (blk_i[c*Z +: Z]),
      .sh_i  (coef_i[c*CW +: SW]),
      .blk_o (rot)
    );
    assign term[c] = coef_i[c*CW + SW] ? rot : '0;
  end

  always_comb begin
    par_o = '0;
    for (int c = 0; c < COLS; c++) par_o = par_o ^ term[c];
  end
endmodule

// File: rtl/ldpc_ext_parity.sv
module ldpc_ext_parity
  import ldpc_ext_pkg::*;
#(
  parameter int Z    = 12,
  parameter int KB   = 22,
  parameter int G    = 4,
  parameter int ROWS = 42,
  localparam int SW    = (Z > 1) ? $clog2(Z) : 1,
  localparam int CW    = SW + 1,
  localparam int COLS  = KB + G,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = $clog2(COLS),
  localparam int NR_W  = $clog2(ROWS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              coef_we_i,
  input  logic [ROW_W-1:0]  coef_row_i,
  input  logic [COL_W-1:0]  coef_col_i,
  input  logic [CW-1:0]     coef_val_i,
  input  logic              start_i,
  input  logic [NR_W-1:0]   nrows_i,
  input  logic [KB*Z-1:0]   info_i,
  input  logic [G*Z-1:0]    core_i,
  output logic [Z-1:0]      blk_o,
  output logic              valid_o,
  output logic              last_o,
  input  logic              ready_i
);
  localparam int TOT   = COLS + ROWS;
  localparam int IDX_W = $clog2(TOT + 1);

  logic              active_q;
  logic [IDX_W-1:0]  idx_q, total_q;
  logic [KB*Z-1:0]   info_q;
  logic [G*Z-1:0]    core_q;
  logic [Z-1:0]      blk_q;
  logic              valid_q, last_q;

  logic              start_ok, load;
  logic [NR_W-1:0]   nr_c;
  seg_e              seg;
  logic [ROW_W-1:0]  row_sel;
  logic [COLS*CW-1:0] row_coef;
  logic [Z-1:0]      ext_blk, blk_n;

  assign start_ok = start_i && !active_q;
  assign load     = active_q && (!valid_q || ready_i) && (idx_q != total_q);

  always_comb begin
    if (nrows_i == '0)                  nr_c = NR_W'(1);
    else if (nrows_i > NR_W'(ROWS))     nr_c = NR_W'(ROWS);
    else                                nr_c = nrows_i;
  end

  always_comb begin
    if (idx_q < IDX_W'(KB))        seg = SEG_INFO;
    else if (idx_q < IDX_W'(COLS)) seg = SEG_CORE;
    else                           seg = SEG_EXT;
  end

  assign row_sel = ROW_W'(idx_q - IDX_W'(COLS));

  ext_coef_store #(
    .ROWS(ROWS), .COLS(COLS), .CW(CW), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (coef_we_i),
    .wrow_i (coef_row_i),
    .wcol_i (coef_col_i),
    .wval_i (coef_val_i),
    .rrow_i (row_sel),
    .rrow_o (row_coef)
  );

  ext_row_xor #(.Z(Z), .SW(SW), .COLS(COLS), .CW(CW)) u_xor (
    .blk_i  ({core_q, info_q}),
    .coef_i (row_coef),
    .par_o  (ext_blk)
  );

  always_comb begin
    unique case (seg)
      SEG_INFO: blk_n = info_q[int'(idx_q)*Z +: Z];
      SEG_CORE: blk_n = core_q[(int'(idx_q) - KB)*Z +: Z];
      default:  blk_n = ext_blk;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      total_q  <= '0;
      info_q   <= '0;
      core_q   <= '0;
      blk_q    <= '0;
      valid_q  <= 1'b0;
      last_q   <= 1'b0;
    end else begin
      if (start_ok) begin
        active_q <= 1'b1;
        idx_q    <= '0;
        total_q  <= IDX_W'(COLS) + IDX_W'(nr_c);
        info_q   <= info_i;
        core_q   <= core_i;
      end else if (valid_q && ready_i && last_q) begin
        active_q <= 1'b0;
      end
      if (load) begin
        blk_q   <= blk_n;
        valid_q <= 1'b1;
        last_q  <= (idx_q == total_q - 1'b1);
        idx_q   <= idx_q + 1'b1;
      end else if (ready_i) begin
        valid_q <= 1'b0;
        last_q  <= 1'b0;
      end
    end
  end

  assign blk_o   = blk_q;
  assign valid_o = valid_q;
  assign last_o  = last_q;

  a_r9_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(blk_o) && $stable(last_o));

  a_r6_last_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  a_r8_gap_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !last_o |=> valid_o);

  a_r11_end_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && last_o |=> !valid_o);
endmodule

// File: tb/ldpc_ext_parity_tb.sv
module ldpc_ext_parity_tb;
  localparam int Z = 12, KB = 22, G = 4, ROWS = 42;
  localparam int SW = $clog2(Z), CW = SW + 1, COLS = KB + G;
  localparam int ROW_W = $clog2(ROWS), COL_W = $clog2(COLS), NR_W = $clog2(ROWS + 1);
  localparam int TOT = COLS + ROWS;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic coef_we_i = 1'b0;
  logic [ROW_W-1:0] coef_row_i = '0;
  logic [COL_W-1:0] coef_col_i = '0;
  logic [CW-1:0] coef_val_i = '0;
  logic start_i = 1'b0;
  logic [NR_W-1:0] nrows_i = '0;
  logic [KB*Z-1:0] info_i = '0;
  logic [G*Z-1:0] core_i = '0;
  logic [Z-1:0] blk_o;
  logic valid_o, last_o;
  logic ready_i = 1'b1;

  ldpc_ext_parity #(.Z(Z), .KB(KB), .G(G), .ROWS(ROWS)) u_dut (.*);

  always #10 clk_i = ~clk_i;

  int errors = 0, checks = 0, cyc = 0;
  int coef_m [ROWS][COLS];
  logic [Z-1:0] exp_blk [TOT];
  logic [Z-1:0] cap_blk [TOT+8];
  logic cap_last [TOT+8];
  int cap_n = 0;

  always @(negedge clk_i)
    if (rst_ni && valid_o && ready_i) begin
      if (cap_n < TOT + 8) begin
        cap_blk[cap_n] = blk_o;
        cap_last[cap_n] = last_o;
      end
      cap_n++;
    end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, expv);
    end
  endtask

  function automatic logic [Z-1:0] rot(logic [Z-1:0] b, int k);
    logic [Z-1:0] r;
    for (int i = 0; i < Z; i++) r[i] = b[(i + k) % Z];
    return r;
  endfunction

  task automatic wr_coef(input int r, input int c, input bit en, input int sh);
    @(negedge clk_i);
    coef_we_i = 1'b1; coef_row_i = ROW_W'(r); coef_col_i = COL_W'(c);
    coef_val_i = {en, SW'(sh)};
    if (r < ROWS && c < COLS) coef_m[r][c] = en ? (sh % Z) : -1;
    @(negedge clk_i);
    coef_we_i = 1'b0;
  endtask

  task automatic run_cw(input int nr, input bit stall, input bit mid_start, input string req_p);
    logic [KB*Z-1:0] inf;
    logic [G*Z-1:0] cor;
    int n, tot, guard;
    for (int w = 0; w < KB*Z; w += 32) inf[w +: 8] = 8'($urandom);
    for (int b = 0; b < KB*Z; b++) inf[b] = 1'($urandom);
    for (int b = 0; b < G*Z; b++) cor[b] = 1'($urandom);
    n = (nr == 0) ? 1 : (nr > ROWS ? ROWS : nr);
    tot = COLS + n;
    for (int j = 0; j < KB; j++) exp_blk[j] = inf[j*Z +: Z];
    for (int j = 0; j < G; j++) exp_blk[KB+j] = cor[j*Z +: Z];
    for (int r = 0; r < n; r++) begin
      logic [Z-1:0] acc = '0;
      for (int c = 0; c < COLS; c++)
        if (coef_m[r][c] >= 0)
          acc ^= rot((c < KB) ? inf[c*Z +: Z] : cor[(c-KB)*Z +: Z], coef_m[r][c]);
      exp_blk[COLS+r] = acc;
    end
    @(negedge clk_i);
    cap_n = 0;
    start_i = 1'b1; nrows_i = NR_W'(nr); info_i = inf; core_i = cor;
    ready_i = stall ? 1'($urandom) : 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; nrows_i = NR_W'(5);
    for (int b = 0; b < KB*Z; b++) info_i[b] = 1'($urandom);
    for (int b = 0; b < G*Z; b++) core_i[b] = 1'($urandom);
    guard = 0;
    while (cap_n < tot && guard < 3000) begin
      @(posedge clk_i); #2;
      guard++;
      if (stall) ready_i = 1'($urandom);
      if (mid_start) start_i = (guard == 10);
    end
    start_i = 1'b0; ready_i = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(cap_n == tot, "R6 length", 32'(cap_n), 32'(tot));
    chk(valid_o == 1'b0, "R11 idle after end", 32'(valid_o), 0);
    for (int i = 0; i < tot && i < TOT + 8; i++) begin
      chk(cap_blk[i] == exp_blk[i], (i < COLS) ? "R6 order" : req_p,
          32'(cap_blk[i]), 32'(exp_blk[i]));
      chk(cap_last[i] == (i == tot - 1), "R6 last flag", 32'(cap_last[i]), 32'(i == tot - 1));
    end
  endtask

  initial begin
    for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++) coef_m[r][c] = -1;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk_i);
    chk(valid_o == 1'b0 && last_o == 1'b0, "R1 reset outputs", {valid_o, last_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    // R1: untouched store gives zero extension blocks
    run_cw(3, 1'b0, 1'b0, "R1 zero store");
    // R2: out-of-range addresses leave the store unchanged
    wr_coef(0, 30, 1'b1, 5);
    wr_coef(50, 0, 1'b1, 5);
    run_cw(2, 1'b0, 1'b0, "R2 range guard");
    // R3 and R5 directed entries, shift 13 wraps to 1
    wr_coef(0, 3, 1'b1, 5);
    wr_coef(0, KB+1, 1'b1, 0);
    wr_coef(1, KB+3, 1'b1, 11);
    wr_coef(2, 0, 1'b1, 13);
    wr_coef(2, 21, 1'b1, 15);
    run_cw(3, 1'b0, 1'b0, "R5 shift wrap");
    // R4: disabled entry contributes nothing
    wr_coef(0, 3, 1'b0, 7);
    run_cw(1, 1'b0, 1'b0, "R4 disabled");
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        wr_coef(r, c, ($urandom % 10) < 7, int'($urandom % 16));
    run_cw(42, 1'b0, 1'b0, "R3 full rows");
    run_cw(17, 1'b1, 1'b0, "R9 stalled");
    run_cw(0, 1'b0, 1'b0, "R7 zero clamps to 1");
    run_cw(60, 1'b1, 1'b0, "R7 high clamps to ROWS");
    run_cw(20, 1'b1, 1'b1, "R10 mid start");
    // R8 latency and gap-free throughput, then R10 start on final accept
    begin
      int n = 0, gaps = 0;
      @(negedge clk_i);
      start_i = 1'b1; nrows_i = NR_W'(5); ready_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      chk(valid_o == 1'b0, "R8 not yet valid", 32'(valid_o), 0);
      @(negedge clk_i);
      chk(valid_o == 1'b1, "R8 first valid", 32'(valid_o), 1);
      n = 1;
      while (!last_o && n < 200) begin
        @(negedge clk_i);
        if (valid_o) n++; else gaps++;
      end
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      chk(n == COLS + 5 && gaps == 0, "R8 beats", 32'(n), 32'(COLS + 5));
      for (int k = 0; k < 4; k++) begin
        @(negedge clk_i);
        chk(valid_o == 1'b0, "R10 start at last accept", 32'(valid_o), 0);
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule